// File: doc/BRIEF.md
# Serial Transmitter with Paced Status Flags

This block turns bytes written by firmware into asynchronous serial frames on a single output line. A byte is first written into a holding register. At the next frame boundary it moves into a shift register, which sends a start bit, eight data bits least significant first, an optional parity bit and one or two stop bits. Each bit lasts one period of an external baud tick.

Firmware paces its writes with two status flags. The "holding empty" flag is set only when a byte moves into the shift register. The "transfer done" flag is set when the line finishes a frame and no further byte is waiting. Firmware clears a flag by reading it while it is 1 and then writing 0 to it. Clearing "holding empty" is also the signal that a new byte is ready. It always clears "transfer done" in the same cycle.

Each flag drives a level interrupt request, gated by its own enable input. Baud-rate generation and interrupt arbitration happen outside the block.

Top module: `sertx_top`

## Requirements
- R1: After reset `txd` is 1, `stsEmpty` is 1, `stsEnd` is 1 and no frame is in progress.
- R2: `stsEmpty` is set to 1 on the baud tick at which the holding register moves into the shift register. The same tick produces the start bit. After firmware clears the flag, it stays 0 until that tick.
- R3: A frame is a start bit of 0, then `wrByte` bits 0 to 7 in that order, then a parity bit when `parityEn`=1, then one stop bit of 1, or two when `twoStop`=1. The parity bit is the XOR of the eight data bits when `parityOdd`=0 and its inverse when `parityOdd`=1. Each bit holds `txd` for exactly one baud-tick period.
- R4: A write on `wrEn` is always taken. When it is made while `stsEmpty` is 0 and before the move, it replaces the waiting byte, and the earlier byte is never sent.
- R5: A pulse on `stsRead` records which flags read as 1. On a `stsWrite`, a 0 in bit 0 of `stsWdata` clears `stsEmpty` and a 0 in bit 1 clears `stsEnd`, but only for a flag recorded as 1 at the last read. Writing 0 without such a read has no effect, and writing 1 has no effect.
- R6: Clearing `stsEmpty` clears `stsEnd` in the same cycle.
- R7: On the tick that ends the last stop bit, `stsEnd` becomes 1 if `stsEmpty` is 1. If `stsEmpty` is 0, the next frame's start bit begins on that same tick with no idle bit, and `stsEnd` stays 0.
- R8: `irqEmpty` equals `stsEmpty` AND `ieEmpty`. `irqEnd` equals `stsEnd` AND `ieEnd`.
- R9: When both requests are pending, clearing `stsEmpty` drops both `irqEmpty` and `irqEnd` in the same cycle.
- R10: While idle with `stsEmpty` at 1, no frame starts and `txd` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baudTick | input | 1 | One-cycle pulse per bit period |
| parityEn | input | 1 | Insert a parity bit |
| parityOdd | input | 1 | Odd parity when 1, even when 0 |
| twoStop | input | 1 | Two stop bits when 1 |
| wrEn | input | 1 | Write strobe for the holding register |
| wrByte | input | 8 | Byte to write |
| stsRead | input | 1 | Status read strobe, records flags that read as 1 |
| stsWrite | input | 1 | Status write strobe |
| stsWdata | input | 2 | Bit 0 is the empty flag, bit 1 is the done flag; 0 clears |
| ieEmpty | input | 1 | Enable for the empty request |
| ieEnd | input | 1 | Enable for the done request |
| txd | output | 1 | Serial line, idles at 1 |
| stsEmpty | output | 1 | Holding-empty flag |
| stsEnd | output | 1 | Transfer-done flag |
| irqEmpty | output | 1 | Empty interrupt request |
| irqEnd | output | 1 | Done interrupt request |

## Verification
The hardest situations to reach are a byte overwritten inside the short window between clearing the empty flag and the next tick, and a second frame queued while the first is still on the line. For the first, the stimulus lines up with a tick, then writes, reads, clears and overwrites within a few cycles of that tick. The bench then confirms that only the second byte appears on the line. For the second, firmware queues the next byte just after the start bit of the current frame. The bench then checks that the next start bit follows the last stop bit directly and that the done flag never rises in between.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  typedef struct packed {
    logic load;
    logic shift;
  } txStrobe_t;
endpackage

// File: rtl/sertx_datapath.sv
module sertx_datapath
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int STOP_MAX = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrByte,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  txStrobe_t         strobe,
  output logic              txd
);
  localparam int FRAME_W = 1 + DATA_W + 1 + STOP_MAX;

  logic [DATA_W-1:0]  holdReg;
  logic [FRAME_W-2:0] shiftReg;
  logic               txdReg;
  logic [FRAME_W-1:0] frameVec;
  logic               parBit;

  assign parBit = parityOdd ^ (^holdReg);

  // frame image: start at bit 0, then data, then parity or stop, rest ones
  always_comb begin
    frameVec = '1;
    frameVec[0] = 1'b0;
    frameVec[DATA_W:1] = holdReg;
    if (parityEn) frameVec[DATA_W+1] = parBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg  <= '0;
      shiftReg <= '1;
      txdReg   <= 1'b1;
    end else begin
      if (wrEn) holdReg <= wrByte;
      if (strobe.load) begin
        txdReg   <= frameVec[0];
        shiftReg <= frameVec[FRAME_W-1:1];
      end else if (strobe.shift) begin
        txdReg   <= shiftReg[0];
        shiftReg <= {1'b1, shiftReg[FRAME_W-2:1]};
      end
    end
  end

  assign txd = txdReg;

  // R3
  property startLow;
    @(posedge clk) disable iff (!rstN) strobe.load |=> !txdReg;
  endproperty
  start_bit_low_chk: assert property (startLow);
endmodule

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int STOP_MAX = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       baudTick,
  input  logic       parityEn,
  input  logic       twoStop,
  input  logic       stsRead,
  input  logic       stsWrite,
  input  logic [1:0] stsWdata,
  output txStrobe_t  strobe,
  output logic       emptyFlag,
  output logic       endFlag,
  output logic       busy
);
  localparam int FRAME_W = 1 + DATA_W + 1 + STOP_MAX;
  localparam int CNT_W = $clog2(FRAME_W + 1);

  logic [CNT_W-1:0] bitsLeft;
  logic [CNT_W-1:0] frameLen;
  logic armEmpty, armEnd;
  logic clrEmpty, clrEnd;
  logic lastBit, boundary, finish;

  assign frameLen = CNT_W'(DATA_W + 2) + CNT_W'(parityEn) + CNT_W'(twoStop);
  assign clrEmpty = stsWrite && !stsWdata[0] && armEmpty;
  assign clrEnd   = stsWrite && !stsWdata[1] && armEnd;
  assign lastBit  = (bitsLeft == '0);
  assign boundary = baudTick && (!busy || lastBit);

  always_comb begin
    strobe.load  = boundary && !emptyFlag;
    strobe.shift = baudTick && busy && !lastBit;
  end
  assign finish = baudTick && busy && lastBit && emptyFlag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      emptyFlag <= 1'b1;
      endFlag   <= 1'b1;
      busy      <= 1'b0;
      bitsLeft  <= '0;
      armEmpty  <= 1'b0;
      armEnd    <= 1'b0;
    end else begin
      if (stsRead) begin
        armEmpty <= emptyFlag;
        armEnd   <= endFlag;
      end else if (stsWrite) begin
        armEmpty <= 1'b0;
        armEnd   <= 1'b0;
      end

      if (strobe.load) emptyFlag <= 1'b1;
      else if (clrEmpty) emptyFlag <= 1'b0;

      if (finish && !clrEmpty) endFlag <= 1'b1;
      else if (clrEmpty || clrEnd) endFlag <= 1'b0;

      if (strobe.load) begin
        busy     <= 1'b1;
        bitsLeft <= frameLen - 1'b1;
      end else if (strobe.shift) begin
        bitsLeft <= bitsLeft - 1'b1;
      end else if (finish) begin
        busy <= 1'b0;
      end
    end
  end

  // R2
  property emptyOnLoad;
    @(posedge clk) disable iff (!rstN) strobe.load |=> emptyFlag;
  endproperty
  empty_set_on_load_chk: assert property (emptyOnLoad);

  // R6
  property endFollowsEmpty;
    @(posedge clk) disable iff (!rstN) $fell(emptyFlag) |-> !endFlag;
  endproperty
  end_cleared_with_empty_chk: assert property (endFollowsEmpty);

  // R7
  property endOnlyIdle;
    @(posedge clk) disable iff (!rstN) $rose(endFlag) |-> !busy;
  endproperty
  end_only_when_idle_chk: assert property (endOnlyIdle);
endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int STOP_MAX = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic              twoStop,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrByte,
  input  logic              stsRead,
  input  logic              stsWrite,
  input  logic [1:0]        stsWdata,
  input  logic              ieEmpty,
  input  logic              ieEnd,
  output logic              txd,
  output logic              stsEmpty,
  output logic              stsEnd,
  output logic              irqEmpty,
  output logic              irqEnd
);
  txStrobe_t strobe;
  logic busy;

  sertx_ctrl #(.DATA_W(DATA_W), .STOP_MAX(STOP_MAX)) uCtrl (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .parityEn(parityEn),
    .twoStop(twoStop), .stsRead(stsRead), .stsWrite(stsWrite),
    .stsWdata(stsWdata), .strobe(strobe), .emptyFlag(stsEmpty),
    .endFlag(stsEnd), .busy(busy)
  );

  sertx_datapath #(.DATA_W(DATA_W), .STOP_MAX(STOP_MAX)) uPath (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrByte(wrByte),
    .parityEn(parityEn), .parityOdd(parityOdd), .strobe(strobe), .txd(txd)
  );

  assign irqEmpty = stsEmpty && ieEmpty;
  assign irqEnd   = stsEnd && ieEnd;

  // R10
  property idleHigh;
    @(posedge clk) disable iff (!rstN) !busy |-> txd;
  endproperty
  idle_line_high_chk: assert property (idleHigh);
endmodule

// File: tb/tb_sertx_top.sv
module tb_sertx_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic baudTick = 1'b0;
  logic parityEn = 1'b0, parityOdd = 1'b0, twoStop = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] wrByte = '0;
  logic stsRead = 1'b0, stsWrite = 1'b0;
  logic [1:0] stsWdata = 2'b11;
  logic ieEmpty = 1'b0, ieEnd = 1'b0;
  logic txd, stsEmpty, stsEnd, irqEmpty, irqEnd;
  int total = 0;
  int bad = 0;
  int tcnt = 0;

  sertx_top dut (.*);

  always #2 clk = ~clk;

  initial forever begin
    @(negedge clk);
    tcnt = (tcnt + 1) % 16;
    baudTick = (tcnt == 0);
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int expLen(input logic pe, input logic ts);
    return 10 + int'(pe) + int'(ts);
  endfunction

  function automatic logic expBit(input logic [7:0] d, input logic pe,
                                  input logic po, input int idx);
    if (idx == 0) return 1'b0;
    if (idx <= 8) return d[idx-1];
    if (idx == 9 && pe) return po ^ (^d);
    return 1'b1;
  endfunction

  task automatic tickWait();
    do @(posedge clk); while (!baudTick);
    @(negedge clk);
  endtask

  task automatic writeByte(input logic [7:0] d);
    wrEn = 1'b1; wrByte = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readSts();
    stsRead = 1'b1;
    @(negedge clk);
    stsRead = 1'b0;
  endtask

  task automatic writeSts(input logic [1:0] v);
    stsWrite = 1'b1; stsWdata = v;
    @(negedge clk);
    stsWrite = 1'b0; stsWdata = 2'b11;
  endtask

  task automatic sendByte(input logic [7:0] d);
    writeByte(d);
    readSts();
    writeSts(2'b10);
  endtask

  task automatic waitLoad(output int n);
    n = 0;
    do begin tickWait(); n++; end while (!stsEmpty && n < 4);
    check(stsEmpty == 1'b1, "R2 load happened", int'(stsEmpty), 1);
  endtask

  task automatic checkRest(input logic [7:0] d, input string tag);
    for (int i = 1; i < expLen(parityEn, twoStop); i++) begin
      tickWait();
      check(txd == expBit(d, parityEn, parityOdd, i), tag, int'(txd),
            int'(expBit(d, parityEn, parityOdd, i)));
    end
  endtask

  task automatic expectFrame(input logic [7:0] d, input string tag);
    int n;
    waitLoad(n);
    check(txd == 1'b0, "R3 start bit", int'(txd), 0);
    checkRest(d, tag);
  endtask

  task automatic expectDone();
    tickWait();
    check(stsEnd == 1'b1, "R7 done after stop", int'(stsEnd), 1);
    check(txd == 1'b1, "R10 line idle", int'(txd), 1);
  endtask

  initial begin
    int n;
    logic [7:0] a, b;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(txd == 1'b1, "R1 txd reset", int'(txd), 1);
    check(stsEmpty == 1'b1, "R1 empty reset", int'(stsEmpty), 1);
    check(stsEnd == 1'b1, "R1 end reset", int'(stsEnd), 1);

    // R10: no frame while empty is 1
    writeByte(8'h5A);
    repeat (3) tickWait();
    check(txd == 1'b1, "R10 no start while empty", int'(txd), 1);

    // R5: clear without a prior read is ignored; writing 1 is ignored
    writeSts(2'b00);
    check(stsEmpty == 1'b1, "R5 empty unread clear", int'(stsEmpty), 1);
    check(stsEnd == 1'b1, "R5 end unread clear", int'(stsEnd), 1);
    readSts();
    writeSts(2'b11);
    check(stsEmpty == 1'b1 && stsEnd == 1'b1, "R5 write one ignored",
          int'({stsEnd, stsEmpty}), 3);

    // R8 and R9: both requests pending, then clear empty
    ieEmpty = 1'b1; ieEnd = 1'b1;
    @(negedge clk);
    check(irqEmpty == 1'b1, "R8 irqEmpty pending", int'(irqEmpty), 1);
    check(irqEnd == 1'b1, "R8 irqEnd pending", int'(irqEnd), 1);
    tickWait();
    writeByte(8'hC3);
    readSts();
    writeSts(2'b10);
    check(irqEmpty == 1'b0 && irqEnd == 1'b0, "R9 both dropped",
          int'({irqEnd, irqEmpty}), 0);
    check(stsEnd == 1'b0, "R6 end cleared with empty", int'(stsEnd), 0);
    check(stsEmpty == 1'b0, "R2 empty held until move", int'(stsEmpty), 0);
    waitLoad(n);
    check(n == 1, "R2 move on first tick", n, 1);
    check(irqEmpty == 1'b1 && irqEnd == 1'b0, "R8 after move",
          int'({irqEnd, irqEmpty}), 1);
    check(txd == 1'b0, "R3 start bit", int'(txd), 0);
    checkRest(8'hC3, "R3 frame C3");
    ieEmpty = 1'b0;
    expectDone();
    check(irqEnd == 1'b1, "R8 irqEnd on done", int'(irqEnd), 1);
    check(irqEmpty == 1'b0, "R8 irqEmpty masked", int'(irqEmpty), 0);
    ieEnd = 1'b0;

    // R5: clear the done flag alone after reading it
    readSts();
    writeSts(2'b01);
    check(stsEnd == 1'b0 && stsEmpty == 1'b1, "R5 end cleared alone",
          int'({stsEnd, stsEmpty}), 1);

    // R4: overwrite while empty is 0, before the move
    tickWait();
    writeByte(8'h11);
    readSts();
    writeSts(2'b10);
    writeByte(8'hE7);
    expectFrame(8'hE7, "R4 overwrite frame");
    expectDone();

    // R7: back-to-back frames
    parityEn = 1'b1; parityOdd = 1'b1; twoStop = 1'b0;
    a = 8'h96; b = 8'h3C;
    tickWait();
    sendByte(a);
    waitLoad(n);
    check(txd == 1'b0, "R3 start bit", int'(txd), 0);
    sendByte(b);
    checkRest(a, "R7 first frame");
    tickWait();
    check(txd == 1'b0, "R7 second start at once", int'(txd), 0);
    check(stsEnd == 1'b0, "R7 no done between frames", int'(stsEnd), 0);
    check(stsEmpty == 1'b1, "R2 second move", int'(stsEmpty), 1);
    checkRest(b, "R7 second frame");
    expectDone();

    // R3: random bytes and configurations
    for (int k = 0; k < 14; k++) begin
      a = 8'($urandom);
      parityEn = 1'($urandom); parityOdd = 1'($urandom); twoStop = 1'($urandom);
      if (k == 0) a = 8'h00;
      if (k == 1) a = 8'hFF;
      tickWait();
      sendByte(a);
      expectFrame(a, "R3 random frame");
      expectDone();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule